// File: doc/BRIEF.md
# LED Channel Gating and Open-String Fault Controller

This block decides, cycle by cycle, which of ten LED driver channels may conduct. Each channel has its own enable bit, and a dimming PWM input gates every channel. In normal mode all enabled channels follow the PWM high time together. In strobe mode only one channel is lit at a time. Each rising PWM edge moves the lit position to the next usable channel, so the outputs scan across the strings.

Each channel also has a comparator input that signals an open LED string. A channel that shows an open string while it is driven is latched as faulted and switched off. The shared fail output is then released, which models an open-drain pin going to high impedance. When the block is under register control, software clears a fault by first disabling the channel and then writing a self-clearing clear bit. In manual mode only a reset removes a fault.

Top module: `led_gate_ctrl`

## Requirements
- R1: Channel i takes its enable from `en_lo[i]` for i in 0..7 and from `en_hi[i-8]` for i in 8..9. A channel whose enable is 0 has its gate at 0 on the next clock.
- R2: In normal mode (`strobe_mode`=0), the gate vector registered on a clock edge equals enable AND NOT fault, with each bit ANDed with `pwm_in` as sampled on that edge.
- R3: When `pwm_in` is 0 on an edge, every gate is 0 after that edge, in either mode.
- R4: In strobe mode at most one gate is 1. On each edge where `pwm_in` is 1 and was 0 on the previous edge, the lit position advances to the next channel.
- R5: In strobe mode the lit channel stays on for as long as `pwm_in` stays high. The scan skips channels that are disabled or faulted and wraps from channel 9 to channel 0. The first rising edge after reset selects the lowest usable channel.
- R6: A fault latches only when `open_det[i]` is 1 on 2 consecutive edges while gate i is 1. A one-cycle pulse latches nothing.
- R7: A faulted channel's gate is 0 from the edge on which the fault latches. `fail_hiz` is 1 whenever any fault is latched.
- R8: With `reg_mode`=1, a one-cycle `clr_fail_wr` pulse clears the fault of every channel whose enable is 0 on that edge. Faults on enabled channels are kept.
- R9: With `reg_mode`=0, `clr_fail_wr` has no effect. Faults persist until reset.
- R10: After a synchronous reset all gates are 0, `fail_hiz` is 0, no fault is latched, and the scan position is channel 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_lo | input | 8 | Enables for channels 0..7 |
| en_hi | input | 2 | Enables for channels 8..9 |
| strobe_mode | input | 1 | 1 = one-channel scan, 0 = normal gating |
| pwm_in | input | 1 | Dimming PWM input |
| reg_mode | input | 1 | 1 = register-controlled, 0 = manual |
| clr_fail_wr | input | 1 | One-cycle write of the clear-fail bit |
| open_det | input | 10 | Per-channel open-string comparator outputs |
| ch_gate | output | 10 | Registered per-channel driver gates |
| fail_hiz | output | 1 | 1 = fail output released (fault present) |

## Verification
Normal gating is driven with all channels enabled, with an enable pattern that uses only the upper-register bits plus a few low bits, and with a checkerboard. These patterns separate a wrong bit mapping from a wrong PWM qualification. Strobe mode is run for more pulses than there are channels, both with all channels enabled and with a sparse enable set, so that the wrap and the skipping of disabled and faulted channels each show up on the outputs. The fault path receives a one-cycle glitch and then a sustained open signal. The bench then attempts clears with the channel still enabled, with it disabled, and in manual mode, which checks each clearing condition on its own.

// File: rtl/led_pkg.sv
package led_pkg;

    localparam int CH_COUNT      = 10;
    localparam int EN_LO_BITS    = 8;
    localparam int OPEN_FILT_LEN = 2;

    typedef enum logic {
        MODE_MANUAL = 1'b0,
        MODE_REG    = 1'b1
    } ctrl_mode_e;

    typedef enum logic {
        GATE_ALL  = 1'b0,
        GATE_SCAN = 1'b1
    } gate_style_e;

    typedef struct packed {
        logic level;
        logic rise;
    } pwm_view_t;

    function automatic ctrl_mode_e to_mode(input logic reg_bit);
        return reg_bit ? MODE_REG : MODE_MANUAL;
    endfunction

    function automatic gate_style_e to_style(input logic strobe_bit);
        return strobe_bit ? GATE_SCAN : GATE_ALL;
    endfunction

endpackage

// File: rtl/led_open_filter.sv
module led_open_filter #(
    parameter int FILT_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic driven,
    input  logic det,
    output logic trip
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FILT_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             active;

    always_comb begin
        active = driven && det;
        trip   = active && (cnt_q >= CNT_TOP);
        if (!active) begin
            cnt_d = '0;
        end else if (cnt_q >= CNT_TOP) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/led_chan_fault.sv
module led_chan_fault #(
    parameter int FILT_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic driven,
    input  logic det,
    input  logic clr_ok,
    output logic fault_q,
    output logic fault_d
);
    logic trip;

    led_open_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .driven (driven),
        .det    (det),
        .trip   (trip)
    );

    always_comb begin
        if (trip) begin
            fault_d = 1'b1;
        end else if (clr_ok) begin
            fault_d = 1'b0;
        end else begin
            fault_d = fault_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= 1'b0;
        end else begin
            fault_q <= fault_d;
        end
    end

endmodule

// File: rtl/led_strobe_scan.sv
module led_strobe_scan #(
    parameter int NUM_CH = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic [NUM_CH-1:0] usable,
    output logic [NUM_CH-1:0] sel_nxt
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_CH - 1);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_d;
    logic [IDX_W-1:0] cand;
    logic             found;

    always_comb begin
        found = 1'b0;
        cand  = idx_q;
        for (int k = 1; k <= NUM_CH; k++) begin
            int j;
            j = (int'(idx_q) + k) % NUM_CH;
            if (!found && usable[j]) begin
                found = 1'b1;
                cand  = IDX_W'(j);
            end
        end
        idx_d = (advance && found) ? cand : idx_q;
    end

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
            assign sel_nxt[g] = (idx_d == IDX_W'(g));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= IDX_LAST;
        end else begin
            idx_q <= idx_d;
        end
    end

endmodule

// File: rtl/led_gate_ctrl.sv
module led_gate_ctrl
    import led_pkg::*;
#(
    parameter int NUM_CH   = CH_COUNT,
    parameter int LO_W     = EN_LO_BITS,
    parameter int FILT_LEN = OPEN_FILT_LEN
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LO_W-1:0]        en_lo,
    input  logic [NUM_CH-LO_W-1:0] en_hi,
    input  logic                   strobe_mode,
    input  logic                   pwm_in,
    input  logic                   reg_mode,
    input  logic                   clr_fail_wr,
    input  logic [NUM_CH-1:0]      open_det,
    output logic [NUM_CH-1:0]      ch_gate,
    output logic                   fail_hiz
);
    logic [NUM_CH-1:0] en_vec;
    logic [NUM_CH-1:0] fault_q;
    logic [NUM_CH-1:0] fault_d;
    logic [NUM_CH-1:0] clr_ok;
    logic [NUM_CH-1:0] sel_nxt;
    logic [NUM_CH-1:0] gate_d;
    logic              pwm_prev_q;
    pwm_view_t         pwm_v;
    ctrl_mode_e        mode;
    gate_style_e       style;

    assign en_vec = {en_hi, en_lo};
    assign mode   = to_mode(reg_mode);
    assign style  = to_style(strobe_mode);

    always_comb begin
        pwm_v.level = pwm_in;
        pwm_v.rise  = pwm_in && !pwm_prev_q;
    end

    always_comb begin
        if (mode == MODE_REG && clr_fail_wr) begin
            clr_ok = ~en_vec;
        end else begin
            clr_ok = '0;
        end
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            led_chan_fault #(.FILT_LEN(FILT_LEN)) u_fault (
                .clk     (clk),
                .rst     (rst),
                .driven  (ch_gate[c]),
                .det     (open_det[c]),
                .clr_ok  (clr_ok[c]),
                .fault_q (fault_q[c]),
                .fault_d (fault_d[c])
            );
        end
    endgenerate

    led_strobe_scan #(.NUM_CH(NUM_CH)) u_scan (
        .clk     (clk),
        .rst     (rst),
        .advance (pwm_v.rise && style == GATE_SCAN),
        .usable  (en_vec & ~fault_q),
        .sel_nxt (sel_nxt)
    );

    always_comb begin
        gate_d = en_vec & ~fault_d & {NUM_CH{pwm_v.level}};
        if (style == GATE_SCAN) begin
            gate_d = gate_d & sel_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_gate    <= '0;
            pwm_prev_q <= 1'b0;
        end else begin
            ch_gate    <= gate_d;
            pwm_prev_q <= pwm_in;
        end
    end

    assign fail_hiz = |fault_q;

endmodule

// File: rtl/led_gate_ctrl_chk.sv
module led_gate_ctrl_chk #(
    parameter int NUM_CH = 10,
    parameter int LO_W   = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic [LO_W-1:0]        en_lo,
    input logic [NUM_CH-LO_W-1:0] en_hi,
    input logic                   strobe_mode,
    input logic                   pwm_in,
    input logic                   reg_mode,
    input logic                   clr_fail_wr,
    input logic [NUM_CH-1:0]      open_det,
    input logic [NUM_CH-1:0]      ch_gate,
    input logic                   fail_hiz,
    input logic [NUM_CH-1:0]      fault_q
);
    logic [NUM_CH-1:0] en_all;
    assign en_all = {en_hi, en_lo};

    a_r1_disabled_dark: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((ch_gate & ~$past(en_all)) == '0));

    a_r3_pwm_low_dark: assert property (@(posedge clk) disable iff (rst)
        !pwm_in |=> (ch_gate == '0));

    a_r4_scan_onehot: assert property (@(posedge clk) disable iff (rst)
        strobe_mode |=> $onehot0(ch_gate));

    a_r6_needs_det: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((fault_q & ~$past(fault_q) & ~$past(open_det & ch_gate)) == '0));

    a_r7_faulted_dark: assert property (@(posedge clk) disable iff (rst)
        (ch_gate & fault_q) == '0);

    a_r7_fail_held: assert property (@(posedge clk) disable iff (rst)
        (fail_hiz && !(reg_mode && clr_fail_wr)) |=> fail_hiz);

    a_r8_enabled_kept: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((fault_q & $past(fault_q & en_all)) == $past(fault_q & en_all)));

    a_r9_manual_sticky: assert property (@(posedge clk) disable iff (rst)
        !reg_mode |=> ((fault_q & $past(fault_q)) == $past(fault_q)));

endmodule

bind led_gate_ctrl led_gate_ctrl_chk #(.NUM_CH(NUM_CH), .LO_W(LO_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .en_lo       (en_lo),
    .en_hi       (en_hi),
    .strobe_mode (strobe_mode),
    .pwm_in      (pwm_in),
    .reg_mode    (reg_mode),
    .clr_fail_wr (clr_fail_wr),
    .open_det    (open_det),
    .ch_gate     (ch_gate),
    .fail_hiz    (fail_hiz),
    .fault_q     (fault_q)
);

// File: tb/led_gate_ctrl_bench.sv
module led_gate_ctrl_bench;
    localparam int N = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   en_lo = '0;
    logic [1:0]   en_hi = '0;
    logic         strobe_mode = 1'b0;
    logic         pwm_in = 1'b0;
    logic         reg_mode = 1'b1;
    logic         clr_fail_wr = 1'b0;
    logic [N-1:0] open_det = '0;
    logic [N-1:0] ch_gate;
    logic         fail_hiz;

    led_gate_ctrl u_led_gate_ctrl (
        .clk         (clk),
        .rst         (rst),
        .en_lo       (en_lo),
        .en_hi       (en_hi),
        .strobe_mode (strobe_mode),
        .pwm_in      (pwm_in),
        .reg_mode    (reg_mode),
        .clr_fail_wr (clr_fail_wr),
        .open_det    (open_det),
        .ch_gate     (ch_gate),
        .fail_hiz    (fail_hiz)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [N-1:0] gate;
        logic         fail;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    bit   done = 0;

    // stimulus set by the test sequence before each step
    logic [N-1:0] s_en = '0;
    logic         s_strb = 0, s_pwm = 0, s_reg = 1, s_clr = 0;
    logic [N-1:0] s_det = '0;

    // requirement model state
    logic [N-1:0] m_gate = '0, m_fault = '0;
    int           m_cnt[N];
    int           m_ptr = N - 1;
    logic         m_pwm_prev = 0;

    task automatic model_apply();
        logic [N-1:0] fnew, usable, g;
        bit rise, found;
        usable = s_en & ~m_fault;
        rise = s_pwm && !m_pwm_prev;
        if (s_strb && rise) begin
            found = 0;
            for (int k = 1; k <= N; k++) begin
                int j;
                j = (m_ptr + k) % N;
                if (!found && usable[j]) begin
                    found = 1;
                    m_ptr = j;
                end
            end
        end
        fnew = m_fault;
        for (int i = 0; i < N; i++) begin
            bit cond;
            cond = m_gate[i] && s_det[i];
            if (s_reg && s_clr && !s_en[i]) fnew[i] = 1'b0;
            if (cond && m_cnt[i] >= 1) fnew[i] = 1'b1;
            m_cnt[i] = cond ? 1 : 0;
        end
        g = s_en & ~fnew & {N{s_pwm}};
        if (s_strb) g = g & (N'(1) << m_ptr);
        m_fault = fnew;
        m_gate = g;
        m_pwm_prev = s_pwm;
    endtask

    // driver: apply inputs, predict, push
    task automatic step(input string tag);
        exp_t e;
        @(negedge clk);
        en_lo = s_en[7:0];
        en_hi = s_en[9:8];
        strobe_mode = s_strb;
        pwm_in = s_pwm;
        reg_mode = s_reg;
        clr_fail_wr = s_clr;
        open_det = s_det;
        model_apply();
        e.gate = m_gate;
        e.fail = |m_fault;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic steps(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic pulses(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            s_pwm = 1; steps(2, tag);
            s_pwm = 0; steps(1, tag);
        end
    endtask

    // monitor: compare after each edge
    always @(posedge clk) begin
        if (!rst && !done) begin
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                total++;
                if (ch_gate !== e.gate || fail_hiz !== e.fail) begin
                    bad++;
                    $display("FAIL %s: gate=%b fail=%b expected gate=%b fail=%b",
                             e.tag, ch_gate, fail_hiz, e.gate, e.fail);
                end
            end
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        total++;
        if (ch_gate !== '0 || fail_hiz !== 1'b0) begin
            bad++;
            $display("FAIL R10 reset: gate=%b fail=%b expected gate=%b fail=0",
                     ch_gate, fail_hiz, {N{1'b0}});
        end

        // R2 normal gating, all enabled, pwm toggling
        s_reg = 1; s_strb = 0; s_en = '1;
        s_pwm = 1; steps(2, "R2 all-on pwm high");
        s_pwm = 0; steps(1, "R2 R3 all-on pwm low");
        s_pwm = 1; steps(1, "R2 all-on pwm high again");
        // R1 mapping: upper-register bits plus some low bits
        s_en = 10'b10_0000_0101; steps(3, "R1 hi/lo enable map");
        s_en = 10'b01_0101_0101; steps(2, "R1 R2 checkerboard");
        s_en = 10'b10_1010_1010; steps(2, "R1 R2 inverse checkerboard");
        // R3 pwm low forces all dark
        s_en = '1; s_pwm = 0; steps(3, "R3 pwm low all dark");

        // R4/R5 strobe scan with wrap
        s_strb = 1;
        pulses(12, "R4 R5 scan all enabled with wrap");
        s_en = 10'b10_0001_0010;
        pulses(5, "R5 scan skips disabled");

        // R6 glitch filter then sustained open
        s_strb = 0; s_en = '1; s_pwm = 1; steps(2, "R2 resume normal");
        s_det = 10'b00_0000_1000; steps(1, "R6 one-cycle glitch");
        s_det = '0; steps(2, "R6 glitch latched nothing");
        s_det = 10'b00_0000_1000; steps(3, "R6 R7 sustained open latches");
        s_det = '0; steps(2, "R7 faulted channel dark, fail released");

        // R5 scan skips faulted channel
        s_strb = 1;
        pulses(6, "R5 scan skips faulted");
        s_strb = 0; s_pwm = 1;

        // R8 clear rules in register mode
        s_clr = 1; steps(1, "R8 clear with channel enabled");
        s_clr = 0; steps(2, "R8 fault kept while enabled");
        s_en = 10'b11_1111_0111; steps(1, "R8 disable faulted channel");
        s_clr = 1; steps(1, "R8 clear with channel disabled");
        s_clr = 0; steps(2, "R8 fault removed");
        s_en = '1; steps(2, "R8 channel back in service");

        // R9 manual mode clear ignored
        s_reg = 0;
        s_det = 10'b00_0010_0000; steps(2, "R9 R6 latch in manual mode");
        s_det = '0; s_en = 10'b11_1101_1111; steps(1, "R9 disable faulted");
        s_clr = 1; steps(1, "R9 clear write in manual mode");
        s_clr = 0; steps(3, "R9 fault persists");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule